// File: doc/BRIEF.md
# Mailbox Receive Queue

This block is the receiving half of an inter-processor mailbox. A remote core delivers messages over a one-cycle push port. Each message is a 3-bit source channel number and a 64-bit payload, and each is stored in a circular queue of `DEPTH` slots.

The local processor reaches the queue through a small register window. It reads the oldest message as three words: channel, low payload and high payload. It then discards that message by writing a one to a trigger register. Popping is never a side effect of a read.

A status word exposes the raw read and write positions and a full flag, so software can work out occupancy itself. A sticky pending bit, gated by a mask, drives an interrupt line that tells the processor mail is waiting. Writing zero to a reset register returns the queue to empty.

Top module: `mbox_rx_fifo`

## Requirements
- R1: Reads return the oldest entry. Offset 0x00 returns its channel in bits 2:0, offset 0x04 returns payload bits 31:0, and offset 0x08 returns payload bits 63:32. `bus_rdata` carries the value in the cycle after the read strobe. All three words read as zero while the queue is empty.
- R2: A write to offset 0x0C with bit 0 set removes exactly one entry. Entries leave in the order they were accepted.
- R3: The status word at offset 0x14 carries the write position in bits 23:16, the read position in bits 31:24 and the full flag in bit 2. Every other bit reads 0. Both positions count modulo `DEPTH`.
- R4: When the two positions are equal, the queue holds `DEPTH` entries if the full flag is set and none if it is clear.
- R5: A push that arrives while the queue is full is discarded and leaves the stored entries and positions unchanged.
- R6: A pop request made while the queue is empty leaves both positions unchanged.
- R7: The pending bit is bit 0 at offset 0x18.
  - It sets on every accepted push.
  - It stays set until a write with bit 0 set clears it. A push in the same cycle as the clear wins.
  - `irq` is a register that follows the pending bit ANDed with the inverse of mask bit 0, one cycle later.
- R8: The mask at offset 0x1C holds 5 bits and resets to 0x1F. While mask bit 0 is set, `irq` stays low.
- R9: Writing the value 0 to offset 0x10 clears both positions, the full flag and the pending bit. A nonzero write to that offset has no effect.
- R10: Offset 0x24 reads as `DEPTH-1`. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Remote side delivers a message this cycle |
| push_chan | input | 3 | Source channel of the delivered message |
| push_data | input | 64 | Payload of the delivered message |
| bus_wen | input | 1 | Register write strobe |
| bus_ren | input | 1 | Register read strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Not-empty interrupt, level |

## Verification
A push, pop, reset or clear takes effect on the same clock edge that samples it, so a status or data read issued afterwards sees the new state. Read data arrives on the edge after the read strobe. The bench therefore drives each strobe for one cycle from a falling edge and samples `bus_rdata` at the next falling edge. `irq` lags the pending bit and the mask by one more register, so the bench waits one extra cycle after a push or a mask change before it samples the line. A scoreboard queue keeps the accepted messages and drops pushes that the model counts as arriving while full. The pop routine compares every dequeued entry against the head of that queue.

// File: rtl/mbox_rx_pkg.sv
package mbox_rx_pkg;
  localparam int CHAN_W = 3;
  localparam int DATA_W = 64;
  localparam int ADDR_W = 6;
  localparam int WORD_W = 32;
  localparam int POS_W  = 8;
  localparam int MASK_W = 5;

  localparam logic [ADDR_W-1:0] OFS_CHAN  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_LO    = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_HI    = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_POP   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_FLUSH = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_PEND  = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_DEPTH = 6'h24;

  localparam int FULL_BIT = 2;

  typedef struct packed {
    logic [CHAN_W-1:0] chan;
    logic [DATA_W-1:0] data;
  } msg_t;
endpackage

// File: rtl/mbox_rx_store.sv
module mbox_rx_store
  import mbox_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  msg_t             wmsg,
  input  logic [IDX_W-1:0] raddr,
  output msg_t             rmsg
);
  msg_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wmsg;
  end

  assign rmsg = mem[raddr];
endmodule

// File: rtl/mbox_rx_ptrs.sv
module mbox_rx_ptrs #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic             flush,
  output logic [IDX_W-1:0] wr_ptr,
  output logic [IDX_W-1:0] rd_ptr,
  output logic             full,
  output logic             empty,
  output logic             push_ok,
  output logic             pop_ok
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (wr_ptr == rd_ptr) && !full;
  assign push_ok = push_req && !full && !flush;
  assign pop_ok  = pop_req && !empty && !flush;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      full   <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= step(wr_ptr);
      if (pop_ok)  rd_ptr <= step(rd_ptr);
      if (push_ok && !pop_ok && (step(wr_ptr) == rd_ptr)) full <= 1'b1;
      else if (pop_ok && !push_ok)                        full <= 1'b0;
    end
  end
endmodule

// File: rtl/mbox_rx_regs.sv
module mbox_rx_regs
  import mbox_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wen,
  input  logic              bus_ren,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  msg_t              head,
  input  logic [IDX_W-1:0]  wr_ptr,
  input  logic [IDX_W-1:0]  rd_ptr,
  input  logic              full,
  input  logic              empty,
  input  logic              push_ok,
  output logic              pop_req,
  output logic              flush,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq,
  output logic              irq_pend,
  output logic [MASK_W-1:0] irq_mask
);
  logic              clr_req;
  logic [WORD_W-1:0] stat_word;
  logic [WORD_W-1:0] rd_mux;
  msg_t              head_vis;

  assign pop_req = bus_wen && (bus_addr == OFS_POP) && bus_wdata[0];
  assign flush   = bus_wen && (bus_addr == OFS_FLUSH) && (bus_wdata == '0);
  assign clr_req = bus_wen && (bus_addr == OFS_PEND) && bus_wdata[0];

  assign head_vis = empty ? '0 : head;

  always_comb begin
    stat_word = '0;
    stat_word[31:24] = POS_W'(rd_ptr);
    stat_word[23:16] = POS_W'(wr_ptr);
    stat_word[FULL_BIT] = full;
  end

  always_comb begin
    case (bus_addr)
      OFS_CHAN:  rd_mux = WORD_W'(head_vis.chan);
      OFS_LO:    rd_mux = head_vis.data[31:0];
      OFS_HI:    rd_mux = head_vis.data[63:32];
      OFS_STAT:  rd_mux = stat_word;
      OFS_PEND:  rd_mux = WORD_W'(irq_pend);
      OFS_MASK:  rd_mux = WORD_W'(irq_mask);
      OFS_DEPTH: rd_mux = WORD_W'(DEPTH - 1);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pend  <= 1'b0;
      irq_mask  <= '1;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (flush)        irq_pend <= 1'b0;
      else if (push_ok) irq_pend <= 1'b1;
      else if (clr_req) irq_pend <= 1'b0;
      if (bus_wen && bus_addr == OFS_MASK) irq_mask <= bus_wdata[MASK_W-1:0];
      irq <= irq_pend && !irq_mask[0];
      if (bus_ren) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/mbox_rx_fifo.sv
module mbox_rx_fifo
  import mbox_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [CHAN_W-1:0] push_chan,
  input  logic [DATA_W-1:0] push_data,
  input  logic              bus_wen,
  input  logic              bus_ren,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq
);
  logic [IDX_W-1:0]  wr_ptr, rd_ptr;
  logic              full, empty, push_ok, pop_ok, pop_req, flush, irq_pend;
  logic [MASK_W-1:0] irq_mask;
  msg_t              head, in_msg;

  assign in_msg = '{chan: push_chan, data: push_data};

  mbox_rx_ptrs #(.DEPTH(DEPTH)) ptrs_i (
    .clk(clk), .rst(rst), .push_req(push_valid), .pop_req(pop_req),
    .flush(flush), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .full(full),
    .empty(empty), .push_ok(push_ok), .pop_ok(pop_ok)
  );

  mbox_rx_store #(.DEPTH(DEPTH)) store_i (
    .clk(clk), .we(push_ok), .waddr(wr_ptr), .wmsg(in_msg),
    .raddr(rd_ptr), .rmsg(head)
  );

  mbox_rx_regs #(.DEPTH(DEPTH)) regs_i (
    .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_ren(bus_ren),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .head(head),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .full(full), .empty(empty),
    .push_ok(push_ok), .pop_req(pop_req), .flush(flush),
    .bus_rdata(bus_rdata), .irq(irq), .irq_pend(irq_pend),
    .irq_mask(irq_mask)
  );
endmodule

// File: rtl/mbox_rx_fifo_chk.sv
module mbox_rx_fifo_chk #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst,
  input logic             push_valid,
  input logic             pop_req,
  input logic             flush,
  input logic [IDX_W-1:0] wr_ptr,
  input logic [IDX_W-1:0] rd_ptr,
  input logic             full,
  input logic             irq_pend,
  input logic             mask0,
  input logic             irq
);
  logic is_empty;
  assign is_empty = (wr_ptr == rd_ptr) && !full;

  assert_full_ptrs_eq_R4: assert property (@(posedge clk) disable iff (rst)
    full |-> (wr_ptr == rd_ptr));

  assert_drop_push_R5: assert property (@(posedge clk) disable iff (rst)
    (full && push_valid && !flush) |=> $stable(wr_ptr));

  assert_empty_pop_R6: assert property (@(posedge clk) disable iff (rst)
    (is_empty && pop_req && !push_valid && !flush) |=> $stable(rd_ptr));

  assert_pend_set_R7: assert property (@(posedge clk) disable iff (rst)
    (push_valid && !full && !flush) |=> irq_pend);

  assert_mask_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    mask0 |=> !irq);

  assert_flush_R9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (wr_ptr == '0 && rd_ptr == '0 && !full && !irq_pend));
endmodule

bind mbox_rx_fifo mbox_rx_fifo_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .push_valid(push_valid), .pop_req(pop_req),
  .flush(flush), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .full(full),
  .irq_pend(irq_pend), .mask0(irq_mask[0]), .irq(irq)
);

// File: tb/mbox_rx_fifo_tb_top.sv
module mbox_rx_fifo_tb_top;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_valid = 1'b0;
  logic [2:0]  push_chan = '0;
  logic [63:0] push_data = '0;
  logic        bus_wen = 1'b0, bus_ren = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  typedef struct { logic [2:0] c; logic [63:0] d; } item_t;
  item_t sb[$];
  int mwr = 0, mrd = 0;
  bit mfull = 0;

  always #4 clk = ~clk;

  mbox_rx_fifo #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_chan(push_chan),
    .push_data(push_data), .bus_wen(bus_wen), .bus_ren(bus_ren),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wen = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_ren = 1; bus_addr = a;
    @(negedge clk);
    bus_ren = 0;
    v = bus_rdata;
  endtask

  // driver: pushes and records expected items
  task automatic push(input logic [2:0] c, input logic [63:0] d);
    @(negedge clk);
    push_valid = 1; push_chan = c; push_data = d;
    @(negedge clk);
    push_valid = 0;
    if (!mfull) begin
      sb.push_back('{c: c, d: d});
      mwr = (mwr + 1) % DEPTH;
      if (mwr == mrd) mfull = 1;
    end
  endtask

  function automatic logic [31:0] exp_stat();
    logic [31:0] s = '0;
    s[31:24] = 8'(mrd); s[23:16] = 8'(mwr); s[2] = mfull;
    return s;
  endfunction

  task automatic stat_check(input string tag);
    logic [31:0] v;
    rd(6'h14, v);
    check(tag, v, exp_stat());
  endtask

  // monitor: reads head, compares with scoreboard, pops
  task automatic pop_check();
    logic [31:0] c, lo, hi;
    item_t e;
    rd(6'h00, c); rd(6'h04, lo); rd(6'h08, hi);
    e = sb.pop_front();
    check("R1 head chan", c, 64'(e.c));
    check("R1 head low", lo, 64'(e.d[31:0]));
    check("R2 order high", hi, 64'(e.d[63:32]));
    wr(6'h0C, 32'h1);
    mrd = (mrd + 1) % DEPTH; mfull = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 0;
    check("R7 irq after reset", irq, 0);
    stat_check("R3 status after reset");
    rd(6'h24, v); check("R10 depth readback", v, DEPTH - 1);
    rd(6'h1C, v); check("R8 mask reset", v, 32'h1F);
    rd(6'h18, v); check("R7 pending reset", v, 0);
    rd(6'h00, v); check("R1 empty head chan", v, 0);
    rd(6'h3C, v); check("R10 unmapped", v, 0);

    push(3'd5, 64'hDEAD_BEEF_0123_4567);
    push(3'd1, 64'h1111_2222_3333_4444);
    push(3'd7, 64'hFFFF_0000_AAAA_5555);
    stat_check("R3 three pushed");
    repeat (3) pop_check();
    stat_check("R3 drained");

    wr(6'h0C, 32'h1);
    stat_check("R6 pop on empty ignored");
    wr(6'h0C, 32'h2);
    stat_check("R2 trigger without bit0");

    for (int i = 0; i < DEPTH; i++)
      push(3'(i), {32'(i * 7 + 1), 32'(32'hA500_0000 + i)});
    stat_check("R4 full with equal positions");
    push(3'd6, 64'hBAD0_BAD0_BAD0_BAD0);
    stat_check("R5 push while full dropped");
    repeat (5) pop_check();
    stat_check("R3 wrapped read ahead of write");
    repeat (DEPTH - 5) pop_check();
    stat_check("R4 empty after full drain");
    rd(6'h04, v); check("R1 empty head low", v, 0);

    wr(6'h18, 32'h1);
    rd(6'h18, v); check("R7 pending cleared", v, 0);
    push(3'd2, 64'h0000_0002_0000_0002);
    rd(6'h18, v); check("R7 pending set by push", v, 1);
    @(negedge clk);
    check("R8 irq masked", irq, 0);
    wr(6'h1C, 32'h1E);
    @(negedge clk);
    check("R7 irq asserted unmasked", irq, 1);
    wr(6'h18, 32'h1);
    @(negedge clk);
    check("R7 irq dropped after clear", irq, 0);

    push(3'd3, 64'h3);
    push(3'd4, 64'h4);
    wr(6'h10, 32'h5);
    stat_check("R9 nonzero reset write ignored");
    wr(6'h10, 32'h0);
    sb.delete(); mwr = 0; mrd = 0; mfull = 0;
    stat_check("R9 positions cleared");
    rd(6'h18, v); check("R9 pending cleared", v, 0);
    rd(6'h00, v); check("R9 head empty", v, 0);
    push(3'd6, 64'h6666_7777_8888_9999);
    pop_check();
    stat_check("R2 after reset reuse");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule